// File: doc/BRIEF.md
# Two-Wire Wiper Register Slave

This block is a slave on a two-wire I2C bus that owns an 8-bit wiper code and a shutdown flag. A controller addresses it with a 7-bit address. The upper six bits of that address are fixed inside the block, and the lowest bit comes from a strap input. A write carries one instruction byte and then any number of data bytes. The instruction byte can force the wiper to midscale and can set or clear shutdown. A read returns the current wiper code directly after the address, with no instruction byte.

SCL and SDA are brought into the system clock domain through a synchronizer chain, and all bus events are decoded from the synchronized levels. The slave never drives SDA high. It only asserts a pull-low enable, which the pad turns into an open-drain driver.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset, wiper_o is 0x80, shutdown_o is 0, and sda_pull_low_o is 0.
- R2: The slave address is the six bits 010110 followed by addr_strap_i. The eighth address bit is the direction bit, where 0 means write and 1 means read. On a match, the slave pulls SDA low during the ninth clock.
- R3: On an address mismatch, the slave acknowledges nothing and changes nothing until the next START.
- R4: Bit 6 of the instruction byte loads 0x80 into the wiper. While that instruction is in force, the data bytes of the same transaction are acknowledged and the wiper stays at 0x80.
- R5: Bit 5 of the instruction byte sets shutdown_o and writing 0 clears it, without changing the wiper code. Data written during shutdown still updates the wiper. Instruction bits 7 and 4 to 0 have no effect.
- R6: Each data byte after the instruction is acknowledged and loaded into the wiper, MSB first. Several data bytes may follow one instruction, and the wiper changes only on an SCL rising edge.
- R7: A read shifts out the wiper MSB first. Further bytes follow while the master acknowledges. A NACK makes the slave release SDA until the next START.
- R8: START (SDA falls while SCL is high) restarts address reception, including in the middle of a transaction. STOP (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R9: sda_pull_low_o changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_strap_i | input | 1 | Lowest bit of the slave address |
| sda_pull_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_o | output | 8 | Wiper code |
| shutdown_o | output | 1 | Shutdown flag |

## Verification
Bus edges reach the decoder through two synchronizer flops and one edge register. A wiper or shutdown update therefore lands about four system clocks after the SCL rising edge that completes a byte. An acknowledge or read bit appears on SDA about four clocks after an SCL falling edge. The bench holds each SCL phase for ten system clocks and samples SDA just before it lowers SCL. It reads wiper_o and shutdown_o only after the STOP has settled for twenty clocks, so every check falls well after its result is due.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam logic [5:0] ADDR_PREFIX = 6'b010110;
  localparam logic [BYTE_W-1:0] MID_CODE = 8'h80;
  localparam int INSTR_RST_BIT = 6;
  localparam int INSTR_SD_BIT = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSTR, ST_INSTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_IGNORE
  } bus_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/wiper_store.sv
module wiper_store
  import wiper_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mid_en_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_code_i,
  input  logic              sd_wr_en_i,
  input  logic              sd_val_i,
  output logic [BYTE_W-1:0] wiper_o,
  output logic              shutdown_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_o    <= MID_CODE;
      shutdown_o <= 1'b0;
    end else begin
      if (mid_en_i)     wiper_o <= MID_CODE;
      else if (wr_en_i) wiper_o <= wr_code_i;
      if (sd_wr_en_i)   shutdown_o <= sd_val_i;
    end
  end
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wiper_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap_i,
  output logic              sda_pull_low_o,
  output logic [BYTE_W-1:0] wiper_o,
  output logic              shutdown_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  bus_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] shift_q, byte_in;
  logic rw_q, ack_on_q, rs_q, nack_q;
  logic byte_end, instr_done, data_done, addr_hit;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  assign byte_in    = {shift_q[BYTE_W-2:0], sda_s};
  assign byte_end   = scl_rise && (cnt_q == LAST_BIT) && !start_det && !stop_det;
  assign instr_done = byte_end && (state_q == ST_INSTR);
  assign data_done  = byte_end && (state_q == ST_WDATA);
  assign addr_hit   = shift_q[6:0] == {ADDR_PREFIX, addr_strap_i};

  wiper_store u_store (
    .clk_i, .rst_ni,
    .mid_en_i  ((instr_done && byte_in[INSTR_RST_BIT]) || (data_done && rs_q)),
    .wr_en_i   (data_done && !rs_q),
    .wr_code_i (byte_in),
    .sd_wr_en_i(instr_done),
    .sd_val_i  (byte_in[INSTR_SD_BIT]),
    .wiper_o,
    .shutdown_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      shift_q  <= '0;
      rw_q     <= 1'b0;
      ack_on_q <= 1'b0;
      rs_q     <= 1'b0;
      nack_q   <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      ack_on_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      ack_on_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_INSTR, ST_WDATA: if (scl_rise) begin
          shift_q <= byte_in;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            if (state_q == ST_ADDR) begin
              rw_q    <= sda_s;
              state_q <= addr_hit ? ST_ADDR_ACK : ST_IGNORE;
            end else if (state_q == ST_INSTR) begin
              rs_q    <= byte_in[INSTR_RST_BIT];
              state_q <= ST_INSTR_ACK;
            end else begin
              state_q <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_INSTR_ACK, ST_WDATA_ACK: if (scl_fall) begin
          // first fall drives the ack, second fall releases it
          if (!ack_on_q) ack_on_q <= 1'b1;
          else begin
            ack_on_q <= 1'b0;
            cnt_q    <= '0;
            if (state_q == ST_ADDR_ACK && rw_q) begin
              state_q <= ST_RDATA;
              shift_q <= wiper_o;
            end else if (state_q == ST_ADDR_ACK) state_q <= ST_INSTR;
            else state_q <= ST_WDATA;
          end
        end
        ST_RDATA: if (scl_fall) begin
          shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) state_q <= ST_RACK;
        end
        ST_RACK: begin
          if (scl_rise) nack_q <= sda_s;
          if (scl_fall) begin
            cnt_q <= '0;
            if (nack_q) state_q <= ST_IGNORE;
            else begin
              state_q <= ST_RDATA;
              shift_q <= wiper_o;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ADDR_ACK, ST_INSTR_ACK, ST_WDATA_ACK: sda_pull_low_o = ack_on_q;
      ST_RDATA: sda_pull_low_o = ~shift_q[BYTE_W-1];
      default:  sda_pull_low_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wiper_i2c_slave_chk.sv
module wiper_i2c_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_pull_low_o,
  input logic [7:0] wiper_o,
  input logic       shutdown_o,
  input logic       scl_s,
  input logic       scl_rise,
  input logic       stop_det
);
  p_reset_mid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (wiper_o == 8'h80 && !shutdown_o));

  p_pull_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_low_o) |-> !scl_s);

  p_wiper_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper_o) |-> $past(scl_rise));

  p_sd_keeps_wiper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shutdown_o) |-> ($stable(wiper_o) || wiper_o == 8'h80));

  p_stop_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_det) |-> !sda_pull_low_o);
endmodule

bind wiper_i2c_slave wiper_i2c_slave_chk u_chk (
  .clk_i, .rst_ni, .sda_pull_low_o, .wiper_o, .shutdown_o,
  .scl_s(scl_s), .scl_rise(scl_rise), .stop_det(stop_det)
);

// File: tb/wiper_i2c_slave_bench.sv
module wiper_i2c_slave_bench;
  localparam int H = 10;
  localparam int NV = 6;
  localparam logic [7:0] V_INSTR [NV] = '{8'h00, 8'h20, 8'h9F, 8'h40, 8'h60, 8'h00};
  localparam logic [7:0] V_DATA  [NV] = '{8'h3C, 8'h55, 8'h07, 8'h11, 8'h22, 8'hA5};
  localparam logic [7:0] V_WIPER [NV] = '{8'h3C, 8'h55, 8'h07, 8'h80, 8'h80, 8'hA5};
  localparam logic       V_SD    [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, strap = 0;
  logic pull, sd;
  logic [7:0] wiper;
  wire sda_line = sda_m & ~pull;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic ack;
  logic [7:0] rb;

  always #5 clk = ~clk;

  wiper_i2c_slave u_wiper_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap_i(strap), .sda_pull_low_o(pull), .wiper_o(wiper), .shutdown_o(sd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic i2c_start;
    sda_m = 1; w(H); scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0; w(H);
  endtask

  task automatic i2c_stop;
    sda_m = 0; w(H); scl_m = 1; w(H); sda_m = 1; w(2 * H);
  endtask

  task automatic xbit(input logic b, output logic r);
    sda_m = b; w(H); scl_m = 1; w(H); r = sda_line; scl_m = 0; w(2);
  endtask

  task automatic send(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) xbit(b[i], r);
    xbit(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv(input logic m_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      xbit(1'b1, r);
      b[i] = r;
    end
    xbit(~m_ack, r);
  endtask

  function automatic logic [7:0] addr_b(input logic s, input logic rd);
    return {6'b010110, s, rd};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    w(5);
    rst_n = 1;
    w(5);
    // R1 reset state
    chk("R1 wiper", wiper, 8'h80);
    chk("R1 shutdown", sd, 0);
    chk("R1 pull", pull, 0);

    // vector walk: R4 R5 R6 through instruction and data pairs
    for (int v = 0; v < NV; v++) begin
      i2c_start;
      send(addr_b(0, 0), ack); chk("R2 addr ack", ack, 1);
      send(V_INSTR[v], ack);   chk("R5 instr ack", ack, 1);
      send(V_DATA[v], ack);    chk("R6 data ack", ack, 1);
      i2c_stop;
      chk("R4/R6 wiper vec", wiper, V_WIPER[v]);
      chk("R5 shutdown vec", sd, V_SD[v]);
    end

    // R7 read with single NACK
    i2c_start;
    send(addr_b(0, 1), ack); chk("R2 read addr ack", ack, 1);
    recv(1'b0, rb); chk("R7 read byte", rb, 8'hA5);
    chk("R7 released after nack", pull, 0);
    i2c_stop;

    // R7 repeated read bytes
    i2c_start;
    send(addr_b(0, 1), ack);
    recv(1'b1, rb); chk("R7 read first", rb, 8'hA5);
    recv(1'b0, rb); chk("R7 read second", rb, 8'hA5);
    i2c_stop;

    // R6 several data bytes after one instruction
    i2c_start;
    send(addr_b(0, 0), ack);
    send(8'h00, ack);
    send(8'h10, ack); chk("R6 multi ack1", ack, 1);
    send(8'h20, ack); chk("R6 multi ack2", ack, 1);
    send(8'h30, ack); chk("R6 multi ack3", ack, 1);
    i2c_stop;
    chk("R6 multi wiper", wiper, 8'h30);

    // R4 reset stays in force for later data bytes
    i2c_start;
    send(addr_b(0, 0), ack);
    send(8'h40, ack);
    send(8'h12, ack); chk("R4 data ack", ack, 1);
    send(8'h34, ack);
    i2c_stop;
    chk("R4 held midscale", wiper, 8'h80);

    // R5 shutdown keeps the register, writes during shutdown apply
    i2c_start; send(addr_b(0, 0), ack); send(8'h00, ack); send(8'h44, ack); i2c_stop;
    i2c_start; send(addr_b(0, 0), ack); send(8'h20, ack); i2c_stop;
    chk("R5 sd set", sd, 1);
    chk("R5 wiper kept", wiper, 8'h44);
    i2c_start; send(addr_b(0, 0), ack); send(8'h20, ack); send(8'h77, ack); i2c_stop;
    chk("R5 write during sd", wiper, 8'h77);
    i2c_start; send(addr_b(0, 0), ack); send(8'h00, ack); i2c_stop;
    chk("R5 sd cleared", sd, 0);
    chk("R5 value applies", wiper, 8'h77);

    // R3 mismatched address
    i2c_start;
    send(addr_b(1, 0), ack); chk("R3 no addr ack", ack, 0);
    send(8'h00, ack);        chk("R3 no instr ack", ack, 0);
    send(8'h01, ack);        chk("R3 no data ack", ack, 0);
    i2c_stop;
    chk("R3 wiper untouched", wiper, 8'h77);

    // R8 repeated START mid-address
    i2c_start;
    begin
      logic r;
      for (int i = 0; i < 4; i++) xbit(1'b0, r);
    end
    i2c_start;
    send(addr_b(0, 0), ack); chk("R8 addr after restart", ack, 1);
    send(8'h00, ack); send(8'h5A, ack);
    i2c_stop;
    chk("R8 write after restart", wiper, 8'h5A);
    chk("R8 idle release", pull, 0);

    // R2 strap selects the low address bit
    strap = 1;
    w(5);
    i2c_start; send(addr_b(0, 0), ack); chk("R2 strap old addr nack", ack, 0); i2c_stop;
    i2c_start; send(addr_b(1, 0), ack); chk("R2 strap new addr ack", ack, 1);
    send(8'h20, ack); send(8'hC3, ack); i2c_stop;
    chk("R2 strap write", wiper, 8'hC3);

    // R1 asynchronous reset mid-run
    rst_n = 0;
    w(3);
    chk("R1 reset wiper", wiper, 8'h80);
    chk("R1 reset sd", sd, 0);
    rst_n = 1;
    w(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule